// File: doc/BRIEF.md
# Two-wire bus controller flag register

This block keeps the hardware-maintained flag bits of a two-wire (SMBus/I2C) controller's control register. A separate bus engine reports what happens on the wire as single-cycle event strobes: a START or STOP was generated or detected, a byte moved, an acknowledge was sampled, or arbitration was lost. Software reaches the register through a write strobe with write data and a combinational read-back word.

Each flag has its own hardware set and clear events. When a set event and a clear event hit the same flag in one cycle, the set wins. A software clear that arrives in the same cycle as a hardware set also loses, so no bus event is dropped. The interrupt request is the interrupt flag gated by a software enable. All state clears on a synchronous, active-high reset.

Register layout, read and write: bit 7 master (read-only), bit 6 transmit mode (read-only), bit 5 start, bit 4 stop, bit 3 acknowledge request (read-only), bit 2 arbitration lost (read-only), bit 1 acknowledge, bit 0 interrupt.

Top module: `smb_flags`

## Requirements
- R1: A cycle with `rst` high clears every flag, so that `ctl_rdata` reads 8'h00 and `irq` reads 0 after the edge.
- R2: Master (bit 7) sets on `ev_start_gen` and clears on `ev_stop_gen` or on any arbitration loss (R7). Set wins over clear.
- R3: Transmit mode (bit 6) sets on `ev_start_gen`, and also on `ev_frame_begin` when the data register was written (`data_wr`) after the previous frame began or in the same cycle. It clears on `ev_start_det`, on arbitration loss, or on `ev_frame_begin` with no such write. Set wins over clear.
- R4: Start (bit 5) sets on `ev_addr_rx`. A control write loads it from write-data bit 5. Hardware never clears it, and a hardware set wins over a write of 0.
- R5: Stop (bit 4) sets on `ev_stop_slave` or `ev_arb_stop`. A control write loads it from bit 4. It clears on `ev_stop_gen`. Priority, highest first: hardware set, then the write, then the clear.
- R6: Acknowledge request (bit 3) sets on `ev_byte_rx` only while `auto_ack_en` is 0, and clears on `ev_ack_done`. Set wins over clear.
- R7: Arbitration lost (bit 2) sets on `ev_scl_stuck`, `ev_sda_clash`, `ev_arb_stop`, or on `ev_rep_start_det` while master is 1 and start is 0. It clears whenever the interrupt flag is cleared by a write (R9). Set wins over clear.
- R8: Acknowledge (bit 1) takes the inverse of `ack_in` on `ev_ack_sample`, where 0 means ACK and reads as 1. Otherwise a control write loads it from bit 1. The sample wins over the write.
- R9: Interrupt (bit 0) sets on `ev_start_gen`, arbitration loss, `ev_ack_sample`, `ev_byte_rx`, `ev_addr_rx` or `ev_stop_rx`. A control write with bit 0 at 0 clears it, and a write of 1 has no effect. Hardware never clears it, and set wins over the write clear.
- R10: `irq` equals interrupt flag AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Interrupt enable |
| auto_ack_en | input | 1 | Hardware acknowledge enabled |
| ev_start_gen | input | 1 | This node generated a START |
| ev_stop_gen | input | 1 | This node generated a STOP |
| ev_start_det | input | 1 | A START was detected on the bus |
| ev_rep_start_det | input | 1 | A repeated START was detected |
| ev_addr_rx | input | 1 | START plus address and R/W received |
| ev_stop_rx | input | 1 | A STOP was received |
| ev_stop_slave | input | 1 | STOP detected while addressed as slave |
| ev_arb_stop | input | 1 | Arbitration lost to a detected STOP |
| ev_scl_stuck | input | 1 | SCL low while producing STOP or repeated START |
| ev_sda_clash | input | 1 | SDA low while driving a 1 on a data bit |
| ev_frame_begin | input | 1 | A new frame begins |
| ev_byte_rx | input | 1 | A byte was received |
| ev_ack_sample | input | 1 | Byte sent and acknowledge sampled |
| ack_in | input | 1 | Sampled acknowledge level (0 = ACK) |
| ev_ack_done | input | 1 | An acknowledge cycle ended |
| data_wr | input | 1 | Software wrote the data register |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register read-back |
| irq | output | 1 | Interrupt request |

## Verification
Random cycles set each event with moderate probability. Many cycles therefore put several set and clear events on the same flag, which separates a correct set-wins order from a reversed one. Control writes with random data land beside hardware events, which exposes a write that overrides a set or a clear-on-write that skips the arbitration flag. Directed runs cover the cases that random stimulus seldom hits: a repeated START seen with and without master held, and a frame that begins with and without a prior data write. A final random phase holds `auto_ack_en` and `irq_en` high, which tells the gated paths apart from the ungated ones.

// File: rtl/smb_flags.sv
module smb_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_en,
  input  logic       auto_ack_en,
  input  logic       ev_start_gen,
  input  logic       ev_stop_gen,
  input  logic       ev_start_det,
  input  logic       ev_rep_start_det,
  input  logic       ev_addr_rx,
  input  logic       ev_stop_rx,
  input  logic       ev_stop_slave,
  input  logic       ev_arb_stop,
  input  logic       ev_scl_stuck,
  input  logic       ev_sda_clash,
  input  logic       ev_frame_begin,
  input  logic       ev_byte_rx,
  input  logic       ev_ack_sample,
  input  logic       ack_in,
  input  logic       ev_ack_done,
  input  logic       data_wr,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  output logic       irq
);

  logic master_q, tx_q, sta_q, sto_q, ackrq_q, arb_q, ack_q, si_q, pend_q;

  wire arb_ev  = (ev_rep_start_det & master_q & ~sta_q) | ev_scl_stuck |
                 ev_sda_clash | ev_arb_stop;
  wire si_clr  = ctl_wr & ~ctl_wdata[0];
  wire si_set  = ev_start_gen | arb_ev | ev_ack_sample | ev_byte_rx |
                 ev_addr_rx | ev_stop_rx;
  wire written = pend_q | data_wr;
  wire tx_set  = ev_start_gen | (ev_frame_begin & written);
  wire tx_clr  = ev_start_det | arb_ev | (ev_frame_begin & ~written);

  always_ff @(posedge clk) begin
    if (rst) begin
      master_q <= 1'b0; tx_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0;
      ackrq_q  <= 1'b0; arb_q <= 1'b0; ack_q <= 1'b0; si_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      if (ev_start_gen)                    master_q <= 1'b1;
      else if (ev_stop_gen | arb_ev)       master_q <= 1'b0;

      if (tx_set)                          tx_q <= 1'b1;
      else if (tx_clr)                     tx_q <= 1'b0;

      if (ev_frame_begin)                  pend_q <= 1'b0;
      else if (data_wr)                    pend_q <= 1'b1;

      if (ev_addr_rx)                      sta_q <= 1'b1;
      else if (ctl_wr)                     sta_q <= ctl_wdata[5];

      if (ev_stop_slave | ev_arb_stop)     sto_q <= 1'b1;
      else if (ctl_wr)                     sto_q <= ctl_wdata[4];
      else if (ev_stop_gen)                sto_q <= 1'b0;

      if (ev_byte_rx & ~auto_ack_en)       ackrq_q <= 1'b1;
      else if (ev_ack_done)                ackrq_q <= 1'b0;

      if (arb_ev)                          arb_q <= 1'b1;
      else if (si_clr)                     arb_q <= 1'b0;

      if (ev_ack_sample)                   ack_q <= ~ack_in;
      else if (ctl_wr)                     ack_q <= ctl_wdata[1];

      if (si_set)                          si_q <= 1'b1;
      else if (si_clr)                     si_q <= 1'b0;
    end
  end

  assign ctl_rdata = {master_q, tx_q, sta_q, sto_q, ackrq_q, arb_q, ack_q, si_q};
  assign irq       = si_q & irq_en;

endmodule

// File: rtl/smb_flags_chk.sv
module smb_flags_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq_en,
  input logic       auto_ack_en,
  input logic       ev_start_gen,
  input logic       ev_stop_gen,
  input logic       ev_rep_start_det,
  input logic       ev_addr_rx,
  input logic       ev_stop_rx,
  input logic       ev_arb_stop,
  input logic       ev_scl_stuck,
  input logic       ev_sda_clash,
  input logic       ev_byte_rx,
  input logic       ev_ack_sample,
  input logic       ack_in,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       irq
);
  wire arb_any = ev_scl_stuck | ev_sda_clash | ev_arb_stop |
                 (ev_rep_start_det & ctl_rdata[7] & ~ctl_rdata[5]);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (ctl_rdata == 8'h00));
  p_master_set_r2: assert property (@(posedge clk) disable iff (rst)
    ev_start_gen |=> ctl_rdata[7]);
  p_master_arb_r2: assert property (@(posedge clk) disable iff (rst)
    (arb_any && !ev_start_gen) |=> !ctl_rdata[7]);
  p_start_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[5] && !ctl_wr) |=> ctl_rdata[5]);
  p_ackrq_set_r6: assert property (@(posedge clk) disable iff (rst)
    (ev_byte_rx && !auto_ack_en) |=> ctl_rdata[3]);
  p_arb_set_r7: assert property (@(posedge clk) disable iff (rst)
    arb_any |=> (ctl_rdata[2] && ctl_rdata[0]));
  p_arb_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_wdata[0] && !arb_any) |=> !ctl_rdata[2]);
  p_ack_follow_r8: assert property (@(posedge clk) disable iff (rst)
    ev_ack_sample |=> (ctl_rdata[1] == !$past(ack_in)));
  p_si_set_r9: assert property (@(posedge clk) disable iff (rst)
    (ev_byte_rx || ev_addr_rx || ev_stop_rx || ev_start_gen) |=> ctl_rdata[0]);
  p_si_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ctl_rdata[0] && !ctl_wr) |=> ctl_rdata[0]);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctl_rdata[0] || !irq_en) |-> !irq);
endmodule

bind smb_flags smb_flags_chk u_chk (.*);

// File: tb/sim_smb_flags.sv
module sim_smb_flags;
  logic clk = 1'b0, rst = 1'b1;
  logic irq_en = 0, auto_ack_en = 0, ev_start_gen = 0, ev_stop_gen = 0,
        ev_start_det = 0, ev_rep_start_det = 0, ev_addr_rx = 0, ev_stop_rx = 0,
        ev_stop_slave = 0, ev_arb_stop = 0, ev_scl_stuck = 0, ev_sda_clash = 0,
        ev_frame_begin = 0, ev_byte_rx = 0, ev_ack_sample = 0, ack_in = 0,
        ev_ack_done = 0, data_wr = 0, ctl_wr = 0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic irq;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic m_ma, m_tx, m_sta, m_sto, m_rq, m_arb, m_ack, m_si, m_pend;

  always #10 clk = ~clk;

  smb_flags u0 (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model();
    logic arb, wr, txs, txc, sic;
    if (rst) begin
      {m_ma, m_tx, m_sta, m_sto, m_rq, m_arb, m_ack, m_si, m_pend} = '0;
      return;
    end
    arb = ev_scl_stuck | ev_sda_clash | ev_arb_stop | (ev_rep_start_det & m_ma & ~m_sta);
    wr  = m_pend | data_wr;
    txs = ev_start_gen | (ev_frame_begin & wr);
    txc = ev_start_det | arb | (ev_frame_begin & ~wr);
    sic = ctl_wr & ~ctl_wdata[0];
    m_ma  = ev_start_gen ? 1'b1 : (ev_stop_gen | arb) ? 1'b0 : m_ma;
    m_tx  = txs ? 1'b1 : txc ? 1'b0 : m_tx;
    m_pend = ev_frame_begin ? 1'b0 : data_wr ? 1'b1 : m_pend;
    m_sta = ev_addr_rx ? 1'b1 : ctl_wr ? ctl_wdata[5] : m_sta;
    m_sto = (ev_stop_slave | ev_arb_stop) ? 1'b1 : ctl_wr ? ctl_wdata[4] :
            ev_stop_gen ? 1'b0 : m_sto;
    m_rq  = (ev_byte_rx & ~auto_ack_en) ? 1'b1 : ev_ack_done ? 1'b0 : m_rq;
    m_arb = arb ? 1'b1 : sic ? 1'b0 : m_arb;
    m_ack = ev_ack_sample ? ~ack_in : ctl_wr ? ctl_wdata[1] : m_ack;
    m_si  = (ev_start_gen | arb | ev_ack_sample | ev_byte_rx | ev_addr_rx | ev_stop_rx) ? 1'b1 :
            sic ? 1'b0 : m_si;
  endtask

  task automatic clear_ev();
    {ev_start_gen, ev_stop_gen, ev_start_det, ev_rep_start_det, ev_addr_rx, ev_stop_rx,
     ev_stop_slave, ev_arb_stop, ev_scl_stuck, ev_sda_clash, ev_frame_begin, ev_byte_rx,
     ev_ack_sample, ev_ack_done, data_wr, ctl_wr} = '0;
  endtask

  task automatic tick();
    model();
    @(posedge clk);
    @(negedge clk);
    clear_ev();
    chk(ctl_rdata[7], m_ma,  "R2 master");
    chk(ctl_rdata[6], m_tx,  "R3 txmode");
    chk(ctl_rdata[5], m_sta, "R4 start");
    chk(ctl_rdata[4], m_sto, "R5 stop");
    chk(ctl_rdata[3], m_rq,  "R6 ackreq");
    chk(ctl_rdata[2], m_arb, "R7 arblost");
    chk(ctl_rdata[1], m_ack, "R8 ack");
    chk(ctl_rdata[0], m_si,  "R9 intflag");
    chk(irq, m_si & irq_en,  "R10 irq");
  endtask

  function automatic logic pick(input int n);
    return ($urandom % n) == 0;
  endfunction

  task automatic rand_cycle(input bit force_en);
    ev_start_gen = pick(6); ev_stop_gen = pick(6); ev_start_det = pick(6);
    ev_rep_start_det = pick(5); ev_addr_rx = pick(7); ev_stop_rx = pick(7);
    ev_stop_slave = pick(7); ev_arb_stop = pick(12); ev_scl_stuck = pick(12);
    ev_sda_clash = pick(12); ev_frame_begin = pick(5); ev_byte_rx = pick(5);
    ev_ack_sample = pick(5); ack_in = pick(2); ev_ack_done = pick(4);
    data_wr = pick(4); ctl_wr = pick(4); ctl_wdata = 8'($urandom);
    auto_ack_en = force_en ? 1'b1 : pick(2);
    irq_en = force_en ? 1'b1 : pick(2);
    tick();
  endtask

  initial begin
    void'($urandom(32'h5EED_0017));
    rst = 1'b1;
    tick(); tick();
    chk(ctl_rdata == 8'h00, 1'b1, "R1 reset word");
    chk(irq, 1'b0, "R1 reset irq");
    rst = 1'b0;
    // repeated START with master set and start low: arbitration loss (R7, R2)
    ev_start_gen = 1; tick();
    ev_rep_start_det = 1; tick();
    // repeated START without master: no loss (R7)
    ctl_wr = 1; ctl_wdata = 8'h00; tick();
    ev_rep_start_det = 1; tick();
    // frame begins with and without prior data write (R3)
    data_wr = 1; tick();
    ev_frame_begin = 1; tick();
    ev_frame_begin = 1; tick();
    data_wr = 1; ev_frame_begin = 1; tick();
    // set beats clear on the same flag (R2, R6, R9, R5)
    ev_start_gen = 1; ev_stop_gen = 1; tick();
    ev_byte_rx = 1; ev_ack_done = 1; tick();
    ev_scl_stuck = 1; ctl_wr = 1; ctl_wdata = 8'h00; tick();
    ev_stop_slave = 1; ev_stop_gen = 1; tick();
    ev_stop_gen = 1; tick();
    // write of 1 to interrupt flag is ignored, ack sample beats write (R9, R8)
    ctl_wr = 1; ctl_wdata = 8'h01; tick();
    ctl_wr = 1; ctl_wdata = 8'h00; ev_ack_sample = 1; ack_in = 0; tick();
    ev_addr_rx = 1; ctl_wr = 1; ctl_wdata = 8'h00; tick();
    for (int i = 0; i < 3000; i++) rand_cycle(1'b0);
    for (int i = 0; i < 500; i++) rand_cycle(1'b1);
    rst = 1'b1; tick();
    chk(ctl_rdata == 8'h00, 1'b1, "R1 reset after traffic");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule